// File: doc/BRIEF.md
# Duplex Evaluator with Encoded Second Lane

This block evaluates a fixed three-input, two-output logic function twice, in two lanes that do not share a representation. Lane 1 keeps the raw input in its own register and evaluates the function on it directly. Lane 2 does not hold the raw input. It holds a 3-bit code word for the class of inputs that give the same result. It evaluates a small three-output network on that code: two bits of result and one flag that says the register holds no legal code.

The code words are chosen so that any two classes differ in at least two bit positions. One stuck bit in lane 2's register therefore either leaves the code unchanged or turns it into an illegal word. It can never turn it into the code of another class. Because of this, a stuck bit in lane 1 and a stuck bit in lane 2 at the same time cannot make the two lanes agree on a wrong answer. The published result is lane 1's word. The error flag rises when the lanes disagree or when lane 2 sees an illegal code. Each lane has its own stuck-at injection controls, so this property can be exercised at the ports.

Top module: `dual_lane_checker`

## Requirements
- R1: With no injection active, `result` equals the function of the input latched at the previous rising edge. Input bits are x=`in_x[2]`, y=`in_x[1]`, z=`in_x[0]`. The function is `result[1]` = x·y' + y·z and `result[0]` = x·y' + y·z'.
- R2: With no injection active, `err` is 0 for every input value. Lane 2 stores code 001 for inputs 000/001, 010 for 010/110, 111 for 011/111 and 100 for 100/101. It decodes these codes to the words 00, 01, 10 and 11 respectively.
- R3: A stuck bit in lane 2 alone never alters `result`.
- R4: When the lane 2 register, after injection, holds any of 000, 011, 101 or 110, `err` is 1.
- R5: With lane 2 clean, `err` is 1 exactly when the stuck bit in lane 1 changes lane 1's word from the correct one.
- R6: With register bit 2 stuck at 1 in both lanes and input 000, `result` is 11 and `err` is 1.
- R7: For every input and every pair of single stuck bits (one per lane, any position, either value), either `result` equals the correct function value or `err` is 1.
- R8: For each lane, `lN_stk_pos` selects the forced register bit (0 = z bit, 1 = y bit, 2 = x bit). The value 3 forces nothing, even with the enable high.
- R9: While reset is held, lane 1's register reads 000 and lane 2's reads code 001, giving `result` 00 and `err` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_x | input | 3 | Function input, latched every edge |
| l1_stk_en | input | 1 | Enable stuck-at forcing on lane 1's register |
| l1_stk_pos | input | 2 | Bit of lane 1's register to force (3 = none) |
| l1_stk_val | input | 1 | Value forced onto lane 1's bit |
| l2_stk_en | input | 1 | Enable stuck-at forcing on lane 2's register |
| l2_stk_pos | input | 2 | Bit of lane 2's register to force (3 = none) |
| l2_stk_val | input | 1 | Value forced onto lane 2's bit |
| result | output | 2 | Lane 1's function word |
| err | output | 1 | Lane mismatch or illegal lane 2 code |

## Verification
The input reaches `result` and `err` one rising edge after it is presented, because both lane registers load on that edge. The injection controls act on the register outputs with no register of their own, so they take effect in the same cycle. The bench changes the input and the injection controls together on a falling edge. It samples one nanosecond after the next rising edge, and the controls stay held until it has sampled. At that point the registers hold the new input and the injection is the one being applied. The expected values come from the input and injection of that single step.

// File: rtl/dual_lane_checker.sv
module dual_lane_checker (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] in_x,
  input  logic       l1_stk_en,
  input  logic [1:0] l1_stk_pos,
  input  logic       l1_stk_val,
  input  logic       l2_stk_en,
  input  logic [1:0] l2_stk_pos,
  input  logic       l2_stk_val,
  output logic [1:0] result,
  output logic       err
);

  logic [2:0] reg1, reg2;
  logic [2:0] code_in;
  logic [2:0] eff1, eff2;
  logic [1:0] word1, word2;
  logic       bad2;
  logic       loaded;

  function automatic logic [2:0] force_bit(logic [2:0] v, logic en, logic [1:0] pos, logic val);
    logic [2:0] r;
    r = v;
    if (en && pos != 2'd3) r[pos] = val;
    return r;
  endfunction

  always_comb begin
    case (in_x)
      3'b000, 3'b001: code_in = 3'b001;
      3'b010, 3'b110: code_in = 3'b010;
      3'b011, 3'b111: code_in = 3'b111;
      default:        code_in = 3'b100;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg1   <= 3'b000;
      reg2   <= 3'b001;
      loaded <= 1'b0;
    end else begin
      reg1   <= in_x;
      reg2   <= code_in;
      loaded <= 1'b1;
    end
  end

  assign eff1 = force_bit(reg1, l1_stk_en, l1_stk_pos, l1_stk_val);
  assign eff2 = force_bit(reg2, l2_stk_en, l2_stk_pos, l2_stk_val);

  always_comb begin
    case (eff1)
      3'b000, 3'b001: word1 = 2'b00;
      3'b010, 3'b110: word1 = 2'b01;
      3'b011, 3'b111: word1 = 2'b10;
      default:        word1 = 2'b11;
    endcase
  end

  always_comb begin
    bad2 = 1'b0;
    case (eff2)
      3'b001:  word2 = 2'b00;
      3'b010:  word2 = 2'b01;
      3'b111:  word2 = 2'b10;
      3'b100:  word2 = 2'b11;
      default: begin word2 = 2'b00; bad2 = 1'b1; end
    endcase
  end

  assign result = word1;
  assign err    = bad2 | (word1 != word2);

  function automatic logic [1:0] eqn(logic [2:0] v);
    return {(v[2] & ~v[1]) | (v[1] & v[0]), (v[2] & ~v[1]) | (v[1] & ~v[0])};
  endfunction

  logic l1_on, l2_on;
  assign l1_on = l1_stk_en && (l1_stk_pos != 2'd3);
  assign l2_on = l2_stk_en && (l2_stk_pos != 2'd3);

  a_r1_clean_result: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && !l1_on) |-> (result == eqn($past(in_x))));

  a_r2_clean_no_error: assert property (@(posedge clk) disable iff (!rst_n)
    (!l1_on && !l2_on) |-> !err);

  a_r2_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    !l2_on |-> !bad2);

  a_r7_fault_secure: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && !err) |-> (result == eqn($past(in_x))));

endmodule

// File: tb/test_dual_lane_checker.sv
module test_dual_lane_checker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] in_x = 3'b000;
  logic       l1_stk_en = 1'b0, l1_stk_val = 1'b0;
  logic [1:0] l1_stk_pos = 2'd0;
  logic       l2_stk_en = 1'b0, l2_stk_val = 1'b0;
  logic [1:0] l2_stk_pos = 2'd0;
  logic [1:0] result;
  logic       err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_lane_checker i_dual_lane_checker (
    .clk(clk), .rst_n(rst_n), .in_x(in_x),
    .l1_stk_en(l1_stk_en), .l1_stk_pos(l1_stk_pos), .l1_stk_val(l1_stk_val),
    .l2_stk_en(l2_stk_en), .l2_stk_pos(l2_stk_pos), .l2_stk_val(l2_stk_val),
    .result(result), .err(err)
  );

  function automatic int fn(int v);
    int x, y, z, a, b;
    x = (v >> 2) & 1; y = (v >> 1) & 1; z = v & 1;
    a = (x & (1 - y)) | (y & z);
    b = (x & (1 - y)) | (y & (1 - z));
    return a * 2 + b;
  endfunction

  function automatic int enc(int v);
    int w;
    w = fn(v);
    if (w == 0) return 1;
    if (w == 1) return 2;
    if (w == 2) return 7;
    return 4;
  endfunction

  function automatic int dec(int c);
    if (c == 1) return 0;
    if (c == 2) return 1;
    if (c == 7) return 2;
    if (c == 4) return 3;
    return -1;
  endfunction

  function automatic int stuck(int v, int en, int pos, int val);
    if (en == 0 || pos == 3) return v;
    if (val != 0) return v | (1 << pos);
    return v & ~(1 << pos);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int x, int e1, int p1, int v1, int e2, int p2, int v2);
    int w1, c2, d2, exp_err, good;
    @(negedge clk);
    in_x = x[2:0];
    l1_stk_en = e1[0]; l1_stk_pos = p1[1:0]; l1_stk_val = v1[0];
    l2_stk_en = e2[0]; l2_stk_pos = p2[1:0]; l2_stk_val = v2[0];
    @(posedge clk);
    #1;
    good = fn(x);
    w1 = fn(stuck(x, e1, p1, v1));
    c2 = stuck(enc(x), e2, p2, v2);
    d2 = dec(c2);
    exp_err = (d2 < 0 || d2 != w1) ? 1 : 0;
    check("R7 fault secure", (int'(result) == good || err) ? 1 : 0, 1);
    check("R5/R2 err model", int'(err), exp_err);
    if (e1 == 0 || p1 == 3) begin
      if (e2 != 0 && p2 != 3) check("R3 lane2 fault keeps result", int'(result), good);
      else check("R1 clean result", int'(result), good);
    end else check("R5 lane1 word", int'(result), w1);
    if (d2 < 0) check("R4 illegal code err", int'(err), 1);
    if ((e1 != 0 && p1 == 3) || (e2 != 0 && p2 == 3)) check("R8 pos3 inert", int'(result), w1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset result", int'(result), 0);
    check("R9 reset err", int'(err), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 1, 2, 1, 1, 2, 1);
    check("R6 result", int'(result), 3);
    check("R6 err", int'(err), 1);
    for (int x = 0; x < 8; x++)
      step(x, 0, 0, 0, 0, 0, 0);
    for (int x = 0; x < 8; x++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++)
          step(x, (a < 7) ? 1 : 0, (a == 6) ? 3 : a / 2, a % 2,
                  (b < 7) ? 1 : 0, (b == 6) ? 3 : b / 2, b % 2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule